// File: doc/BRIEF.md
# Quadword Load Register-Pair Sequencer

This block carries out a 16-byte load into a pair of adjacent 64-bit registers. The pair is made of an even register and the odd register numbered one above it. A start request brings in the effective address, the even register number and a byte-order mode. The block then makes two doubleword reads over a valid/ready read-request channel and takes one response for each read. After both reads it sends two register-write commands on consecutive cycles and ends with a one-cycle completion pulse.

The byte-order mode decides which register each doubleword goes to and whether its bytes are reordered. In big-endian order the data is written unchanged, with the lower-addressed doubleword in the even register. In little-endian order each doubleword has its bytes reversed, and the two doublewords trade places in the pair. An odd register number is refused: the block raises an error flag and makes no read. Effective-address arithmetic and the register file are handled by the surrounding pipeline.

Top module: `quad_pair_loader`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy_o`, `rd_req_valid_o`, `wr_en_o`, `done_o` and `err_o` are all 0.
- R2: When idle, a start with an odd `rt_i` (bit 0 = 1) raises `err_o` for exactly the next cycle. No read request is issued and `busy_o` stays 0.
- R3: When idle, a start with an even `rt_i` begins a load. The first read request is addressed at `ea_i` and the second at `ea_i + 8`. Each request holds valid and its address steady until `rd_req_ready_i` is seen.
- R4: A response is taken only after its request has been accepted, and only one response is taken per read. The request valid is 0 from acceptance until that response arrives.
- R5: With `le_i` = 0 at start, the even register `rt` is written with the response data of the first read. On the next cycle the odd register `rt + 1` is written with the response data of the second read.
- R6: With `le_i` = 1 at start, the even register is written with the byte-reversed data of the second read. The odd register is then written with the byte-reversed data of the first read. Byte reversal moves byte k (bits 8k+7:8k) to byte 7-k.
- R7: `done_o` is high for exactly one cycle, the cycle right after the odd-register write.
- R8: A start request is ignored from the cycle the load begins through the `done_o` cycle. It causes no error, and its address, register and mode do not change the load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only while idle |
| ea_i | input | ADDR_W | Effective address of the quadword |
| rt_i | input | REG_W | Even target register number |
| le_i | input | 1 | 1 = little-endian, 0 = big-endian |
| busy_o | output | 1 | A load is in progress |
| err_o | output | 1 | One-cycle pulse: start refused because the register number is odd |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Memory accepts the read request |
| rd_req_addr_o | output | ADDR_W | Doubleword read address |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | 64 | Read response data |
| wr_en_o | output | 1 | Register write command valid |
| wr_reg_o | output | REG_W | Register number to write |
| wr_data_o | output | 64 | Data to write |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall on the same clock edge: a new start request and the completion pulse of the load in progress. The bench raises `start_i` with an odd register number in the exact cycle where `done_o` is high, and again while the first read is still waiting for ready. The start is judged ignored if `err_o` stays 0, the block returns to idle with no new read request, and the register writes of the running load match the values predicted from the original request.

// File: rtl/qld_pkg.sv
package qld_pkg;

    localparam int DW    = 64;
    localparam int NBYTE = DW / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_LO,
        ST_READ_HI,
        ST_WRITE_EVEN,
        ST_WRITE_ODD,
        ST_DONE
    } qld_state_e;

    function automatic logic [DW-1:0] swap_bytes(input logic [DW-1:0] d);
        logic [DW-1:0] r;
        for (int i = 0; i < NBYTE; i++) begin
            r[8*i +: 8] = d[8*(NBYTE-1-i) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/qld_seq.sv
module qld_seq
    import qld_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic [REG_W-1:0]  rt_i,
    input  logic              le_i,
    input  logic              rd_req_ready_i,
    input  logic              rd_rsp_valid_i,
    output qld_state_e        state_o,
    output logic              rd_req_valid_o,
    output logic [ADDR_W-1:0] rd_req_addr_o,
    output logic              cap_lo_o,
    output logic              cap_hi_o,
    output logic [REG_W-1:0]  base_reg_o,
    output logic              le_q_o,
    output logic              err_o
);

    localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(NBYTE);

    qld_state_e        state;
    logic              issued;
    logic [ADDR_W-1:0] ea_q;
    logic [REG_W-1:0]  rt_q;
    logic              le_q;
    logic              in_read;

    assign in_read        = (state == ST_READ_LO) || (state == ST_READ_HI);
    assign rd_req_valid_o = in_read && !issued;
    assign rd_req_addr_o  = (state == ST_READ_HI) ? ea_q + HI_OFS : ea_q;
    assign cap_lo_o       = (state == ST_READ_LO) && issued && rd_rsp_valid_i;
    assign cap_hi_o       = (state == ST_READ_HI) && issued && rd_rsp_valid_i;
    assign state_o        = state;
    assign base_reg_o     = rt_q;
    assign le_q_o         = le_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            issued <= 1'b0;
            ea_q   <= '0;
            rt_q   <= '0;
            le_q   <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            err_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        if (rt_i[0]) begin
                            err_o <= 1'b1;
                        end else begin
                            ea_q   <= ea_i;
                            rt_q   <= rt_i;
                            le_q   <= le_i;
                            issued <= 1'b0;
                            state  <= ST_READ_LO;
                        end
                    end
                end
                ST_READ_LO, ST_READ_HI: begin
                    if (!issued) begin
                        if (rd_req_ready_i) issued <= 1'b1;
                    end else if (rd_rsp_valid_i) begin
                        issued <= 1'b0;
                        state  <= (state == ST_READ_LO) ? ST_READ_HI : ST_WRITE_EVEN;
                    end
                end
                ST_WRITE_EVEN: state <= ST_WRITE_ODD;
                ST_WRITE_ODD:  state <= ST_DONE;
                default:       state <= ST_IDLE;
            endcase
        end
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o));

    // R2
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (state == ST_IDLE) && !rd_req_valid_o);

    // R4
    one_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        cap_lo_o |=> rd_req_valid_o && !cap_hi_o);

endmodule

// File: rtl/qld_steer.sv
module qld_steer
    import qld_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  qld_state_e        state_i,
    input  logic              cap_lo_i,
    input  logic              cap_hi_i,
    input  logic [DW-1:0]     rsp_data_i,
    input  logic [REG_W-1:0]  base_reg_i,
    input  logic              le_i,
    output logic              wr_en_o,
    output logic [REG_W-1:0]  wr_reg_o,
    output logic [DW-1:0]     wr_data_o
);

    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo_i) lo_q <= rsp_data_i;
            if (cap_hi_i) hi_q <= rsp_data_i;
        end
    end

    always_comb begin
        wr_en_o   = 1'b0;
        wr_reg_o  = base_reg_i;
        wr_data_o = '0;
        case (state_i)
            ST_WRITE_EVEN: begin
                wr_en_o   = 1'b1;
                wr_data_o = le_i ? swap_bytes(hi_q) : lo_q;
            end
            ST_WRITE_ODD: begin
                wr_en_o   = 1'b1;
                wr_reg_o  = {base_reg_i[REG_W-1:1], 1'b1};
                wr_data_o = le_i ? swap_bytes(lo_q) : hi_q;
            end
            default: ;
        endcase
    end

    // R5
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o && !wr_reg_o[0] |=> wr_en_o && (wr_reg_o == $past(wr_reg_o) + REG_W'(1)));

endmodule

// File: rtl/quad_pair_loader.sv
module quad_pair_loader
    import qld_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic [REG_W-1:0]  rt_i,
    input  logic              le_i,
    output logic              busy_o,
    output logic              err_o,
    output logic              rd_req_valid_o,
    input  logic              rd_req_ready_i,
    output logic [ADDR_W-1:0] rd_req_addr_o,
    input  logic              rd_rsp_valid_i,
    input  logic [63:0]       rd_rsp_data_i,
    output logic              wr_en_o,
    output logic [REG_W-1:0]  wr_reg_o,
    output logic [63:0]       wr_data_o,
    output logic              done_o
);

    qld_state_e       state;
    logic             cap_lo;
    logic             cap_hi;
    logic [REG_W-1:0] base_reg;
    logic             le_q;

    qld_seq #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .ea_i           (ea_i),
        .rt_i           (rt_i),
        .le_i           (le_i),
        .rd_req_ready_i (rd_req_ready_i),
        .rd_rsp_valid_i (rd_rsp_valid_i),
        .state_o        (state),
        .rd_req_valid_o (rd_req_valid_o),
        .rd_req_addr_o  (rd_req_addr_o),
        .cap_lo_o       (cap_lo),
        .cap_hi_o       (cap_hi),
        .base_reg_o     (base_reg),
        .le_q_o         (le_q),
        .err_o          (err_o)
    );

    qld_steer #(.REG_W(REG_W)) u_steer (
        .clk        (clk),
        .rst        (rst),
        .state_i    (state),
        .cap_lo_i   (cap_lo),
        .cap_hi_i   (cap_hi),
        .rsp_data_i (rd_rsp_data_i),
        .base_reg_i (base_reg),
        .le_i       (le_q),
        .wr_en_o    (wr_en_o),
        .wr_reg_o   (wr_reg_o),
        .wr_data_o  (wr_data_o)
    );

    assign busy_o = (state != ST_IDLE);
    assign done_o = (state == ST_DONE);

    // R7
    done_once_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    done_after_odd_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(wr_en_o && wr_reg_o[0]));

    // R8
    no_err_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o && start_i |=> !err_o);

endmodule

// File: tb/sim_quad_pair_loader.sv
module sim_quad_pair_loader;

    localparam int AW = 64;
    localparam int RW = 5;

    typedef struct packed {
        logic [63:0]   ea;
        logic [RW-1:0] rt;
        logic          le;
        logic [63:0]   lo;
        logic [63:0]   hi;
        logic [3:0]    rdy_dly;
        logic [3:0]    rsp_dly;
        logic          poke;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_1000, 5'd4,  1'b0, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 4'd0, 4'd0, 1'b0},
        '{64'h0000_0000_0000_2000, 5'd10, 1'b1, 64'h0102_0304_0506_0708, 64'hA1A2_A3A4_A5A6_A7A8, 4'd2, 4'd1, 1'b0},
        '{64'h0000_0001_0000_0FF0, 5'd0,  1'b0, 64'hDEAD_BEEF_0BAD_F00D, 64'h1234_5678_9ABC_DEF0, 4'd3, 4'd2, 1'b1},
        '{64'hFFFF_FFFF_FFFF_FFF0, 5'd30, 1'b1, 64'hFEDC_BA98_7654_3210, 64'h0F1E_2D3C_4B5A_6978, 4'd1, 4'd3, 1'b1},
        '{64'h0000_0000_00AB_CD00, 5'd16, 1'b1, 64'hFFFF_0000_FFFF_0000, 64'h0000_0000_0000_0001, 4'd0, 4'd4, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] ea_i = '0;
    logic [RW-1:0] rt_i = '0;
    logic          le_i = 1'b0;
    logic          rd_req_ready_i = 1'b0;
    logic          rd_rsp_valid_i = 1'b0;
    logic [63:0]   rd_rsp_data_i = '0;
    logic          busy_o, err_o, rd_req_valid_o, wr_en_o, done_o;
    logic [AW-1:0] rd_req_addr_o;
    logic [RW-1:0] wr_reg_o;
    logic [63:0]   wr_data_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    quad_pair_loader #(.ADDR_W(AW), .REG_W(RW)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .ea_i(ea_i), .rt_i(rt_i), .le_i(le_i),
        .busy_o(busy_o), .err_o(err_o), .rd_req_valid_o(rd_req_valid_o),
        .rd_req_ready_i(rd_req_ready_i), .rd_req_addr_o(rd_req_addr_o),
        .rd_rsp_valid_i(rd_rsp_valid_i), .rd_rsp_data_i(rd_rsp_data_i),
        .wr_en_o(wr_en_o), .wr_reg_o(wr_reg_o), .wr_data_o(wr_data_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [63:0] rev8(input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
        return r;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic serve_read(input logic [63:0] addr, input logic [63:0] data,
                              input int rdy_dly, input int rsp_dly);
        for (int k = 0; k < rdy_dly; k++) begin
            check(rd_req_valid_o && rd_req_addr_o == addr, "R3 held request", rd_req_addr_o, addr);
            @(negedge clk);
        end
        check(rd_req_valid_o && rd_req_addr_o == addr, "R3 request address", rd_req_addr_o, addr);
        rd_req_ready_i = 1'b1;
        @(negedge clk);
        rd_req_ready_i = 1'b0;
        check(!rd_req_valid_o, "R4 valid low after accept", 64'(rd_req_valid_o), 64'd0);
        for (int k = 0; k < rsp_dly; k++) @(negedge clk);
        rd_rsp_valid_i = 1'b1;
        rd_rsp_data_i  = data;
        @(negedge clk);
        rd_rsp_valid_i = 1'b0;
        rd_rsp_data_i  = '0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [63:0] exp_even, exp_odd;
        exp_even = v.le ? rev8(v.hi) : v.lo;
        exp_odd  = v.le ? rev8(v.lo) : v.hi;
        start_i = 1'b1; ea_i = v.ea; rt_i = v.rt; le_i = v.le;
        @(negedge clk);
        start_i = 1'b0;
        if (v.poke) begin
            start_i = 1'b1; ea_i = ~v.ea; rt_i = v.rt ^ RW'(3); le_i = ~v.le;
            @(negedge clk);
            start_i = 1'b0;
            check(!err_o && busy_o, "R8 start while busy ignored", 64'(err_o), 64'd0);
        end
        serve_read(v.ea, v.lo, int'(v.rdy_dly), int'(v.rsp_dly));
        serve_read(v.ea + 64'd8, v.hi, int'(v.rdy_dly), int'(v.rsp_dly));
        check(wr_en_o && wr_reg_o == v.rt, "R5 even register number", 64'(wr_reg_o), 64'(v.rt));
        if (v.le) check(wr_data_o == exp_even, "R6 even data", wr_data_o, exp_even);
        else      check(wr_data_o == exp_even, "R5 even data", wr_data_o, exp_even);
        @(negedge clk);
        check(wr_en_o && wr_reg_o == (v.rt | RW'(1)), "R5 odd register number", 64'(wr_reg_o), 64'(v.rt | RW'(1)));
        if (v.le) check(wr_data_o == exp_odd, "R6 odd data", wr_data_o, exp_odd);
        else      check(wr_data_o == exp_odd, "R5 odd data", wr_data_o, exp_odd);
        @(negedge clk);
        check(done_o && !wr_en_o, "R7 done after odd write", 64'(done_o), 64'd1);
        start_i = 1'b1; rt_i = 5'd7; ea_i = 64'h40;
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o, "R7 done one cycle", 64'(done_o), 64'd0);
        check(!err_o && !busy_o && !rd_req_valid_o, "R8 start during done ignored",
              {61'd0, err_o, busy_o, rd_req_valid_o}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !rd_req_valid_o && !wr_en_o && !done_o && !err_o, "R1 outputs in reset",
              {59'd0, busy_o, rd_req_valid_o, wr_en_o, done_o, err_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !rd_req_valid_o && !wr_en_o && !done_o && !err_o, "R1 outputs after reset",
              {59'd0, busy_o, rd_req_valid_o, wr_en_o, done_o, err_o}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2: odd register number refused
        start_i = 1'b1; rt_i = 5'd3; ea_i = 64'h500; le_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o, "R2 error raised", 64'(err_o), 64'd1);
        check(!rd_req_valid_o && !busy_o, "R2 no read", {62'd0, rd_req_valid_o, busy_o}, 64'd0);
        @(negedge clk);
        check(!err_o && !rd_req_valid_o, "R2 error one cycle", 64'(err_o), 64'd0);

        // R2 then R3: refused start followed by a valid load
        run_vec(VECS[0]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule